// File: doc/BRIEF.md
# Interrupt-Gated Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with a small register bank on a simple synchronous CPU bus. Software sets the frame options and enables in a control register. It watches a status register for transmit-empty, receive-full and three receive error conditions. Bytes move through a transmit-data register and a receive-data register. Frames are one start bit, eight data bits sent LSB first, an optional even-parity bit and one stop bit. The bit rate is fixed by a parameter at 16 receive sample ticks per bit.

Status flags are sticky. A flag can be cleared only by software. Software must read the status register while the flag shows 1, and then write 0 to that bit. A transmission starts when the transmit-empty flag is cleared this way while the transmitter is enabled. The receive-interrupt-enable bit gates two interrupt lines: one for receive-full and one for any receive error.

Top module: `sio_core`

## Requirements
- R1: After reset, the control register (address 0) reads 0. The status register (address 1) reads 0x01, with only transmit-empty set. The serial output idles high and both interrupt lines are low.
- R2: While the transmit-enable bit (control bit 0) is 0, transmit-empty (status bit 0) stays 1, even after a read followed by a write of 0, and no frame is sent.
- R3: With transmit-enable 1, a transmission starts when transmit-empty is cleared. The frame is the byte last written to address 2, framed as start 0, 8 data bits LSB first, then an even-parity bit if the parity-enable bit (control bit 3) is 1, then stop 1. Transmit-empty returns to 1 once the byte is taken.
- R4: With receive-enable (control bit 1) set, a received frame places its byte in the receive-data register (address 3) and sets receive-full (status bit 1).
- R5: A stop bit sampled as 0 sets framing-error (status bit 2).
- R6: With parity enabled, a received parity bit that does not give even parity over the data and parity bits sets parity-error (status bit 3). A correct parity bit leaves it clear.
- R7: A frame that completes while receive-full is 1 sets overrun (status bit 4). The receive-data register keeps its old byte.
- R8: A write of 0 to a status bit clears it only if that bit was read as 1 since it last set. Writes of 1 to status bits have no effect.
- R9: The receive-full interrupt equals receive-interrupt-enable (control bit 2) AND receive-full. The error interrupt equals receive-interrupt-enable AND the OR of framing-error, parity-error and overrun. Clearing the enable bit drops both lines.
- R10: With receive-enable 0, frames on the input are ignored, and the receive status flags and the receive-data register keep their values.
- R11: A low pulse on the serial input that is gone by mid-bit does not start a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; arms status flags that read as 1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ser_txd | output | 1 | Serial transmit output |
| ser_rxd | input | 1 | Serial receive input, asynchronous |
| irq_rx_full | output | 1 | Receive-full interrupt |
| irq_rx_err | output | 1 | Receive-error interrupt |

## Verification
The read data path has no register, so the bench samples a register value in the same cycle it raises the read strobe. A write takes effect at the clock edge that ends its cycle, so it is seen on the next read. A received frame sets its flags about two synchronizer cycles plus one tick after the middle of the stop bit. The bench therefore samples status only after it has driven the whole stop bit. A transmit frame begins two cycles after the clearing write, so the bench locks onto the falling start edge and samples each bit at its centre. The interrupt lines follow the registered flags and enable directly, so they are checked in the same cycle as the status reads.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TDAT = 2'd2,
    REG_RDAT = 2'd3
  } reg_addr_t;

  localparam int C_TEN = 0;
  localparam int C_REN = 1;
  localparam int C_RIE = 2;
  localparam int C_PAR = 3;
  localparam int NCTRL = 4;

  localparam int S_TXE = 0;
  localparam int S_RXF = 1;
  localparam int S_FER = 2;
  localparam int S_PER = 3;
  localparam int S_OVR = 4;
  localparam int NFLAG = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tx_ld,
  input  logic       rx_done,
  input  logic [7:0] rx_byte,
  input  logic       rx_fe,
  input  logic       rx_pe,
  output logic       ten,
  output logic       ren,
  output logic       par_en,
  output logic [7:0] tdr,
  output logic       tx_req,
  output logic       irq_rxi,
  output logic       irq_eri
);
  logic [NCTRL-1:0] ctrl_q, ctrl_d;
  logic [NFLAG-1:0] flg_q, flg_d, arm_q, arm_d, set_v, clr_v;
  logic [7:0]       tdr_q, tdr_d, rdr_q, rdr_d;
  logic             wr_ctrl, wr_stat, wr_tdat, rd_stat, take;

  assign wr_ctrl = wr && (addr == REG_CTRL);
  assign wr_stat = wr && (addr == REG_STAT);
  assign wr_tdat = wr && (addr == REG_TDAT);
  assign rd_stat = rd && (addr == REG_STAT);
  assign take    = rx_done && !flg_q[S_RXF];

  always_comb begin
    ctrl_d = wr_ctrl ? wdata[NCTRL-1:0] : ctrl_q;
    tdr_d  = wr_tdat ? wdata : tdr_q;
    rdr_d  = take ? rx_byte : rdr_q;
    set_v        = '0;
    set_v[S_TXE] = tx_ld;
    set_v[S_RXF] = take;
    set_v[S_FER] = take && rx_fe;
    set_v[S_PER] = take && rx_pe;
    set_v[S_OVR] = rx_done && flg_q[S_RXF];
    for (int i = 0; i < NFLAG; i++) begin
      clr_v[i] = wr_stat && !wdata[i] && arm_q[i];
      flg_d[i] = set_v[i] | (flg_q[i] & ~clr_v[i]);
      if (clr_v[i] || (set_v[i] && !flg_q[i]))
        arm_d[i] = 1'b0;
      else if (rd_stat && flg_q[i])
        arm_d[i] = 1'b1;
      else
        arm_d[i] = arm_q[i];
    end
    if (!ctrl_q[C_TEN])
      flg_d[S_TXE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flg_q  <= NFLAG'(1) << S_TXE;
      arm_q  <= '0;
      tdr_q  <= '0;
      rdr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flg_q  <= flg_d;
      arm_q  <= arm_d;
      if (wr_tdat) tdr_q <= tdr_d;
      if (take)    rdr_q <= rdr_d;
    end
  end

  always_comb begin
    unique case (addr)
      REG_CTRL: rdata = {{(8-NCTRL){1'b0}}, ctrl_q};
      REG_STAT: rdata = {{(8-NFLAG){1'b0}}, flg_q};
      REG_TDAT: rdata = tdr_q;
      default:  rdata = rdr_q;
    endcase
  end

  assign ten     = ctrl_q[C_TEN];
  assign ren     = ctrl_q[C_REN];
  assign par_en  = ctrl_q[C_PAR];
  assign tdr     = tdr_q;
  assign tx_req  = ctrl_q[C_TEN] && !flg_q[S_TXE];
  assign irq_rxi = ctrl_q[C_RIE] && flg_q[S_RXF];
  assign irq_eri = ctrl_q[C_RIE] && (flg_q[S_FER] || flg_q[S_PER] || flg_q[S_OVR]);

  // R8
  rxf_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flg_q[S_RXF]) |-> $past(wr_stat && !wdata[S_RXF]));
  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_done && flg_q[S_RXF]) |=> $stable(rdr_q));
  // R10
  ren_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ren && !rx_done && !wr_stat) |=> $stable(flg_q[S_OVR:S_RXF]));
  // R2
  txe_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ten |=> flg_q[S_TXE]);
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int CLK_PER_BIT = 64
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       tx_req,
  input  logic [7:0] tdr,
  input  logic       par_en,
  output logic       tx_ld,
  output logic       txd
);
  localparam int CW = $clog2(CLK_PER_BIT);
  localparam logic [CW-1:0] BMAX = CW'(CLK_PER_BIT - 1);

  logic [CW-1:0] bcnt_q, bcnt_d;
  logic [10:0]   sh_q, sh_d;
  logic [3:0]    left_q, left_d;
  logic          busy;

  assign busy  = (left_q != 4'd0);
  assign tx_ld = tx_req && !busy;

  always_comb begin
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    left_d = left_q;
    if (tx_ld) begin
      sh_d   = {1'b1, (par_en ? ^tdr : 1'b1), tdr, 1'b0};
      left_d = par_en ? 4'd11 : 4'd10;
      bcnt_d = '0;
    end else if (busy) begin
      if (bcnt_q == BMAX) begin
        bcnt_d = '0;
        sh_d   = {1'b1, sh_q[10:1]};
        left_d = left_q - 4'd1;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (tx_ld || busy) begin
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign txd = busy ? sh_q[0] : 1'b1;

  // R3
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_ld |=> !txd);
  // R3
  tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && bcnt_q != BMAX && !tx_ld) |=> $stable(txd));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int OS       = 16
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       rxd,
  input  logic       ren,
  input  logic       par_en,
  output logic       done,
  output logic [7:0] byte_o,
  output logic       fe,
  output logic       pe
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int OW = $clog2(OS);
  localparam logic [TW-1:0] TMAX = TW'(TICK_DIV - 1);
  localparam logic [OW-1:0] HALF = OW'(OS / 2 - 1);
  localparam logic [OW-1:0] LAST = OW'(OS - 1);

  logic          s1_q, s2_q, prev_q, prev_d, tick;
  logic [TW-1:0] tdiv_q;
  rx_state_t     st_q, st_d;
  logic [OW-1:0] tcnt_q, tcnt_d;
  logic [2:0]    bitn_q, bitn_d;
  logic [7:0]    sh_q, sh_d;
  logic          parb_q, parb_d, done_q, done_d, fe_q, fe_d, pe_q, pe_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      tdiv_q <= '0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      tdiv_q <= (tdiv_q == TMAX) ? '0 : tdiv_q + 1'b1;
    end
  end
  assign tick = (tdiv_q == TMAX);

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bitn_d = bitn_q;
    sh_d   = sh_q;
    parb_d = parb_q;
    done_d = 1'b0;
    fe_d   = fe_q;
    pe_d   = pe_q;
    prev_d = tick ? s2_q : prev_q;
    if (!ren) begin
      st_d = RX_IDLE;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: if (prev_q && !s2_q) begin
          st_d   = RX_START;
          tcnt_d = '0;
        end
        RX_START: if (tcnt_q == HALF) begin
          st_d   = s2_q ? RX_IDLE : RX_DATA;
          tcnt_d = '0;
          bitn_d = '0;
        end else tcnt_d = tcnt_q + 1'b1;
        RX_DATA: if (tcnt_q == LAST) begin
          tcnt_d = '0;
          sh_d   = {s2_q, sh_q[7:1]};
          bitn_d = bitn_q + 1'b1;
          if (bitn_q == 3'd7) st_d = par_en ? RX_PAR : RX_STOP;
        end else tcnt_d = tcnt_q + 1'b1;
        RX_PAR: if (tcnt_q == LAST) begin
          tcnt_d = '0;
          parb_d = s2_q;
          st_d   = RX_STOP;
        end else tcnt_d = tcnt_q + 1'b1;
        default: if (tcnt_q == LAST) begin
          done_d = 1'b1;
          fe_d   = !s2_q;
          pe_d   = par_en && (parb_q != ^sh_q);
          st_d   = RX_IDLE;
        end else tcnt_d = tcnt_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      parb_q <= 1'b0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      prev_q <= prev_d;
      if (tick) begin
        tcnt_q <= tcnt_d;
        bitn_q <= bitn_d;
        sh_q   <= sh_d;
        parb_q <= parb_d;
        fe_q   <= fe_d;
        pe_q   <= pe_d;
      end
    end
  end

  assign done   = done_q;
  assign byte_o = sh_q;
  assign fe     = fe_q;
  assign pe     = pe_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  // R10
  ren_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ren |=> (st_q == RX_IDLE && !done));
  // R11
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ren && tick && st_q == RX_START && tcnt_q == HALF && s2_q) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/sio_core.sv
module sio_core #(
  parameter int TICK_DIV = 4,
  parameter int OS       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ser_txd,
  input  logic       ser_rxd,
  output logic       irq_rx_full,
  output logic       irq_rx_err
);
  localparam int CLK_PER_BIT = OS * TICK_DIV;

  logic       rst_m_q, rst_s_q;
  logic       ten, ren, par_en, tx_req, tx_ld, rx_done, rx_fe, rx_pe;
  logic [7:0] tdr, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  sio_regs u_regs (
    .clk     (clk),
    .rst_ni  (rst_s_q),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .tx_ld   (tx_ld),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .rx_fe   (rx_fe),
    .rx_pe   (rx_pe),
    .ten     (ten),
    .ren     (ren),
    .par_en  (par_en),
    .tdr     (tdr),
    .tx_req  (tx_req),
    .irq_rxi (irq_rx_full),
    .irq_eri (irq_rx_err)
  );

  sio_tx #(.CLK_PER_BIT(CLK_PER_BIT)) u_tx (
    .clk    (clk),
    .rst_ni (rst_s_q),
    .tx_req (tx_req),
    .tdr    (tdr),
    .par_en (par_en),
    .tx_ld  (tx_ld),
    .txd    (ser_txd)
  );

  sio_rx #(.TICK_DIV(TICK_DIV), .OS(OS)) u_rx (
    .clk    (clk),
    .rst_ni (rst_s_q),
    .rxd    (ser_rxd),
    .ren    (ren),
    .par_en (par_en),
    .done   (rx_done),
    .byte_o (rx_byte),
    .fe     (rx_fe),
    .pe     (rx_pe)
  );

  // R3
  tx_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    tx_ld |-> ten);
endmodule

// File: tb/sio_core_tb.sv
module sio_core_tb;
  localparam int BIT = 64;

  logic       clk, rst_n, bus_wr, bus_rd, ser_rxd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ser_txd, irq_rx_full, irq_rx_err;
  int         total, bad;

  logic [7:0] m_rdr;
  logic       m_rxf, m_fer, m_per, m_ovr;

  sio_core u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_txd(ser_txd), .ser_rxd(ser_rxd),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_stat(input logic txe);
    return {3'b0, m_ovr, m_per, m_fer, m_rxf, txe};
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit pen, input bit badpar, input bit badstop);
    @(negedge clk);
    ser_rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (pen) begin
      ser_rxd = (^d) ^ badpar;
      repeat (BIT) @(negedge clk);
    end
    ser_rxd = !badstop;
    repeat (BIT) @(negedge clk);
    ser_rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic model_rx(input logic [7:0] d, input bit pen, input bit badpar, input bit badstop);
    if (m_rxf) m_ovr = 1'b1;
    else begin
      m_rdr = d; m_rxf = 1'b1;
      if (badstop) m_fer = 1'b1;
      if (pen && badpar) m_per = 1'b1;
    end
  endtask

  task automatic cap_tx(input bit pen, output logic [7:0] d, output logic p, output logic stp, output bit seen);
    int t;
    t = 0; seen = 0; d = '0; p = 1'b0; stp = 1'b0;
    while (ser_txd !== 1'b0 && t < 20) begin @(negedge clk); t++; end
    if (ser_txd === 1'b0) begin
      seen = 1;
      repeat (BIT/2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        d[i] = ser_txd;
      end
      if (pen) begin repeat (BIT) @(negedge clk); p = ser_txd; end
      repeat (BIT) @(negedge clk);
      stp = ser_txd;
      repeat (BIT) @(negedge clk);
    end
  endtask

  task automatic chk_irqs(input logic rie, input string tag);
    chk(irq_rx_full == (rie && m_rxf), {tag, " R9 rxi"}, irq_rx_full, rie && m_rxf);
    chk(irq_rx_err == (rie && (m_fer || m_per || m_ovr)), {tag, " R9 eri"}, irq_rx_err,
        rie && (m_fer || m_per || m_ovr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, d, dt;
    logic       p, stp;
    bit         seen, pen, bp, bs, rie;
    int         t;
    void'($urandom(32'h5EED_1234));
    total = 0; bad = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; ser_rxd = 1'b1;
    m_rdr = 0; m_rxf = 0; m_fer = 0; m_per = 0; m_ovr = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, r); chk(r == 8'h00, "R1 ctrl", r, 0);
    bus_read(2'd1, r); chk(r == 8'h01, "R1 stat", r, 1);
    chk(ser_txd == 1'b1, "R1 txd", ser_txd, 1);
    chk(!irq_rx_full && !irq_rx_err, "R1 irq", {irq_rx_full, irq_rx_err}, 0);

    // R2 transmit-empty held while transmitter off
    bus_write(2'd2, 8'h3C);
    bus_read(2'd1, r);
    bus_write(2'd1, 8'h00);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ser_txd == 1'b0) seen = 1; end
    bus_read(2'd1, r);
    chk(r[0] == 1'b1, "R2 txe held", r, 1);
    chk(!seen, "R2 no frame", seen, 0);

    // R11 short glitch rejected
    bus_write(2'd0, 8'h02);
    @(negedge clk); ser_rxd = 1'b0;
    repeat (12) @(negedge clk); ser_rxd = 1'b1;
    repeat (BIT*12) @(negedge clk);
    bus_read(2'd1, r); chk(r == 8'h01, "R11 glitch stat", r, 1);

    // R10 receiver off ignores frames
    bus_write(2'd0, 8'h00);
    send_frame(8'h77, 0, 0, 0);
    bus_read(2'd1, r); chk(r == 8'h01, "R10 off stat", r, 1);
    bus_read(2'd3, r); chk(r == 8'h00, "R10 off rdr", r, 0);

    // R4 basic receive, R9 rie=0
    bus_write(2'd0, 8'h02);
    send_frame(8'hA5, 0, 0, 0); model_rx(8'hA5, 0, 0, 0);
    bus_read(2'd3, r); chk(r == 8'hA5, "R4 rdr", r, 8'hA5);
    chk_irqs(0, "rie0");

    // R8 clear needs prior read-as-1; writes of 1 ignored
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, r); chk(r == 8'h03, "R8 no-read clear ignored", r, 3);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, r); chk(r == 8'h03, "R8 write1 ignored", r, 3);
    bus_write(2'd1, 8'h01);
    bus_read(2'd1, r); chk(r == 8'h01, "R8 read then clear", r, 1);
    m_rxf = 0;

    // R10 flags retained across receive-disable
    send_frame(8'h5C, 0, 0, 1); model_rx(8'h5C, 0, 0, 1);
    bus_write(2'd0, 8'h00);
    repeat (20) @(negedge clk);
    bus_read(2'd1, r); chk(r == exp_stat(1), "R10 retained R5 fer", r, exp_stat(1));
    bus_read(2'd3, r); chk(r == 8'h5C, "R10 rdr retained", r, 8'h5C);
    bus_write(2'd1, 8'h01); m_rxf = 0; m_fer = 0;

    // R7 overrun keeps old byte, R9 gating and cancel
    bus_write(2'd0, 8'h02);
    send_frame(8'h11, 0, 0, 0); model_rx(8'h11, 0, 0, 0);
    send_frame(8'h22, 0, 0, 0); model_rx(8'h22, 0, 0, 0);
    bus_read(2'd3, r); chk(r == 8'h11, "R7 rdr kept", r, 8'h11);
    bus_read(2'd1, r); chk(r == exp_stat(1), "R7 ovr", r, exp_stat(1));
    chk_irqs(0, "ovr rie0");
    bus_write(2'd0, 8'h06); @(negedge clk); chk_irqs(1, "ovr rie1");
    bus_write(2'd0, 8'h02); @(negedge clk); chk_irqs(0, "rie cleared");
    bus_write(2'd0, 8'h06);
    bus_read(2'd1, r); bus_write(2'd1, 8'h01);
    m_rxf = 0; m_ovr = 0; @(negedge clk); chk_irqs(1, "flags cleared");

    // R6 parity good and bad
    bus_write(2'd0, 8'h0A);
    send_frame(8'h96, 1, 0, 0); model_rx(8'h96, 1, 0, 0);
    bus_read(2'd1, r); chk(r == exp_stat(1), "R6 good parity", r, exp_stat(1));
    bus_write(2'd1, 8'h01); m_rxf = 0;
    send_frame(8'h31, 1, 1, 0); model_rx(8'h31, 1, 1, 0);
    bus_read(2'd1, r); chk(r == exp_stat(1), "R6 bad parity", r, exp_stat(1));
    bus_write(2'd1, 8'h01); m_rxf = 0; m_per = 0;

    // random receive traffic (R4 R5 R6 R7 R8 R9)
    for (int n = 0; n < 30; n++) begin
      pen = $urandom_range(0, 1); rie = $urandom_range(0, 1);
      bp = ($urandom_range(0, 5) == 0); bs = ($urandom_range(0, 5) == 0);
      d = 8'($urandom);
      bus_write(2'd0, {4'b0, pen, rie, 1'b1, 1'b0});
      send_frame(d, pen, bp, bs); model_rx(d, pen, bp, bs);
      bus_read(2'd1, r); chk(r == exp_stat(1), "R4 rand stat", r, exp_stat(1));
      bus_read(2'd3, r); chk(r == m_rdr, "R7 rand rdr", r, m_rdr);
      chk_irqs(rie, "rand");
      if ($urandom_range(0, 3) != 0) begin
        bus_read(2'd1, r); bus_write(2'd1, 8'h01);
        m_rxf = 0; m_fer = 0; m_per = 0; m_ovr = 0;
        bus_read(2'd1, r); chk(r == 8'h01, "R8 rand clear", r, 1);
      end
    end
    bus_read(2'd1, r); bus_write(2'd1, 8'h01);
    m_rxf = 0; m_fer = 0; m_per = 0; m_ovr = 0;

    // R3 transmit, directed then random
    for (int n = 0; n < 14; n++) begin
      pen = (n == 0) ? 1'b0 : 1'($urandom_range(0, 1));
      dt  = (n == 0) ? 8'h5A : 8'($urandom);
      bus_write(2'd0, {4'b0, pen, 3'b001});
      bus_write(2'd2, dt);
      bus_read(2'd1, r);
      bus_write(2'd1, 8'hFE);
      cap_tx(pen, d, p, stp, seen);
      chk(seen, "R3 start seen", seen, 1);
      chk(d == dt, "R3 data", d, dt);
      if (pen) chk(p == ^dt, "R3 parity", p, ^dt);
      chk(stp == 1'b1, "R3 stop", stp, 1);
      bus_read(2'd1, r); chk(r[0] == 1'b1, "R3 txe back", r, 1);
    end

    // R2 disabling transmitter forces empty
    bus_write(2'd0, 8'h01);
    bus_write(2'd2, 8'hC3);
    bus_read(2'd1, r);
    bus_write(2'd1, 8'hFE);
    bus_write(2'd0, 8'h00);
    t = 0;
    while (ser_txd == 1'b0 || t < BIT*12) begin @(negedge clk); t++; end
    bus_read(2'd1, r); chk(r[0] == 1'b1, "R2 txe after disable", r, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule